// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block decides which operating mode a CAN controller is in: initialization, sleep or normal. Software writes two request bits, init and sleep, and reads back acknowledge bits that hardware sets once the requested mode is in force. Entering initialization or sleep takes effect at once. Returning to normal from either of them waits until the receive line has been idle for eleven recessive bit times in a row. This lets the controller join the bus only between frames.

The block also keeps three sticky event flags: sleep entered, wakeup and error. Software clears each flag by writing a one to it. A single state-change interrupt line is raised whenever a flag is set and its enable bit is set. While the controller sleeps, a dominant bit on the bus marks a start of frame and sets the wakeup flag. If automatic wakeup is enabled, the same event also clears the sleep request, so the controller heads back to normal without software.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, status_o is 5'b00010 (sleep acknowledge set, all other bits clear), sleep_req_o is 1 and irq_o is 0.
- R2: A control write with the init bit set is captured at the first clock edge. At the following edge, status bit 0 (init acknowledge) becomes 1 and status bit 1 (sleep acknowledge) becomes 0. The two acknowledge bits are never both 1.
- R3: While the captured init request is 1, the block enters or stays in init mode even when the sleep request is also 1.
- R4: With both requests clear, the pending acknowledge bit (bit 0 or bit 1) clears at the edge that samples the 11th consecutive recessive bit, a bit being rx_i=1 while bit_stb_i=1. A dominant strobed bit restarts the count, and cycles without bit_stb_i count for nothing.
- R5: A captured sleep request, with the init request clear, sets status bit 1 at the next edge. One edge after status bit 1 rises, the sleep-entered flag at status bit 4 is set.
- R6: In sleep mode, a strobed dominant bit sets the wakeup flag at status bit 3 at that edge. With auto_wake_i=1 it also clears sleep_req_o at that edge. With auto_wake_i=0 the request stays 1 and the block stays in sleep.
- R7: The error flag at status bit 2 is set one edge after an err_stat_i bit goes from 0 to 1 while the matching err_en_i bit is 1. A rising error bit whose enable is 0 has no effect.
- R8: A clear write (clr_wr_i=1) clears each of status bits 2, 3 and 4 whose clr_mask_i bit is 1. Mask bits 0 and 1 have no effect. A set event in the same cycle wins over the clear.
- R9: The sleep-entered flag is cleared by hardware one edge after status bit 1 falls.
- R10: irq_o is 1 exactly when a flag is set together with its enable: bit 4 with irq_en_i[0], bit 3 with irq_en_i[1], bit 2 with irq_en_i[2]. irq_o follows irq_en_i with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control write strobe for the request bits |
| ctrl_init_i | input | 1 | Init request value written |
| ctrl_sleep_i | input | 1 | Sleep request value written |
| auto_wake_i | input | 1 | Clear the sleep request on start of frame |
| irq_en_i | input | 3 | Enables: [0] sleep-entered, [1] wakeup, [2] error |
| err_stat_i | input | NUM_ERR | Per-type error status bits |
| err_en_i | input | NUM_ERR | Per-type error flag enables |
| rx_i | input | 1 | Receive bus level, 1 = recessive |
| bit_stb_i | input | 1 | One-cycle pulse at each bit sample point |
| clr_wr_i | input | 1 | Write-1-to-clear strobe for the flags |
| clr_mask_i | input | 5 | Bits to clear, laid out as status_o |
| status_o | output | 5 | [0] init ack, [1] sleep ack, [2] error, [3] wakeup, [4] sleep entered |
| sleep_req_o | output | 1 | Current sleep request, including hardware clears |
| irq_o | output | 1 | State-change interrupt |

## Verification
Request writes show up on the acknowledge bits two edges after the write is driven. Start-of-frame events, error edges and clears show up one edge after they are driven. The sleep-entered flag trails a rise or fall of the sleep acknowledge by one more edge, and irq_o responds to its enables within the same cycle. The bench drives every input at the falling edge and samples after exactly the number of rising edges listed above. Enable changes are checked a short delay after they are driven, with no edge in between. The recessive count is checked one strobe short of eleven, after a dominant restart, and across cycles with no strobe, to pin down the exact edge at which an acknowledge drops.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_SLEEP  = 2'd2
  } mode_e;

  // status_o layout
  localparam int unsigned ST_INIT_ACK  = 0;
  localparam int unsigned ST_SLEEP_ACK = 1;
  localparam int unsigned ST_ERR       = 2;
  localparam int unsigned ST_WAKE      = 3;
  localparam int unsigned ST_SLAK      = 4;
  localparam int unsigned ST_W         = 5;

  // irq_en_i layout
  localparam int unsigned IE_SLAK = 0;
  localparam int unsigned IE_WAKE = 1;
  localparam int unsigned IE_ERR  = 2;
  localparam int unsigned IE_W    = 3;

  // sticky flag index inside the flag bank
  localparam int unsigned FL_ERR  = 0;
  localparam int unsigned FL_WAKE = 1;
  localparam int unsigned FL_SLAK = 2;
  localparam int unsigned FL_N    = 3;
endpackage

// File: rtl/can_mode_sync.sv
module can_mode_sync #(
  parameter int unsigned SYNC_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic rx_i,
  input  logic bit_stb_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rec_bit, dom_bit;

  assign rec_bit = bit_stb_i & rx_i;
  assign dom_bit = bit_stb_i & ~rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!arm_i)        cnt_q <= '0;
    else if (dom_bit)       cnt_q <= '0;
    else if (rec_bit && cnt_q < LAST) cnt_q <= cnt_q + 1'b1;
  end

  // the strobe that would make the count reach SYNC_BITS
  assign done_o = arm_i & rec_bit & (cnt_q == LAST);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST) else $error("sync count out of range"); // R4
  AST_DOM_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dom_bit |=> cnt_q == '0) else $error("dominant bit did not restart count"); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i && !bit_stb_i && $past(arm_i) |=> $stable(cnt_q) || !arm_i) else $error("count moved without strobe"); // R4
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic ctrl_init_i,
  input  logic ctrl_sleep_i,
  input  logic auto_wake_i,
  input  logic rx_i,
  input  logic bit_stb_i,
  input  logic sync_done_i,
  output logic arm_o,
  output logic sof_o,
  output logic init_ack_o,
  output logic sleep_ack_o,
  output logic sleep_req_o
);
  mode_e mode_q, mode_d;
  logic  init_req_q, sleep_req_q;

  assign sof_o = (mode_q == MODE_SLEEP) & bit_stb_i & ~rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_req_q  <= 1'b0;
      sleep_req_q <= 1'b1;
    end else if (ctrl_wr_i) begin
      init_req_q  <= ctrl_init_i;
      sleep_req_q <= ctrl_sleep_i;
    end else if (sof_o && auto_wake_i) begin
      sleep_req_q <= 1'b0;
    end
  end

  // init wins over sleep; leaving to normal waits for bus idle
  always_comb begin
    mode_d = mode_q;
    if (init_req_q)                              mode_d = MODE_INIT;
    else if (sleep_req_q)                        mode_d = MODE_SLEEP;
    else if (mode_q != MODE_NORMAL && sync_done_i) mode_d = MODE_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_SLEEP;
    else         mode_q <= mode_d;
  end

  assign arm_o       = (mode_q != MODE_NORMAL) & ~init_req_q & ~sleep_req_q;
  assign init_ack_o  = (mode_q == MODE_INIT);
  assign sleep_ack_o = (mode_q == MODE_SLEEP);
  assign sleep_req_o = sleep_req_q;

  AST_ONE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(init_ack_o && sleep_ack_o)) else $error("both acknowledges set"); // R2
  AST_INIT_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_q |=> init_ack_o) else $error("init request not honoured"); // R3
  AST_AUTO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o && auto_wake_i && !ctrl_wr_i |=> !sleep_req_o) else $error("auto wakeup missed"); // R6
  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_q && !init_req_q |=> sleep_ack_o) else $error("sleep request not honoured"); // R5
endmodule

// File: rtl/can_mode_irq.sv
module can_mode_irq
  import can_mode_pkg::*;
#(
  parameter int unsigned NUM_ERR = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sleep_ack_i,
  input  logic               sof_i,
  input  logic [NUM_ERR-1:0] err_stat_i,
  input  logic [NUM_ERR-1:0] err_en_i,
  input  logic               clr_wr_i,
  input  logic [ST_W-1:0]    clr_mask_i,
  input  logic [IE_W-1:0]    irq_en_i,
  output logic [FL_N-1:0]    flags_o,
  output logic               irq_o
);
  logic [NUM_ERR-1:0] err_q;
  logic               ack_d_q;
  logic [FL_N-1:0]    set_v, clr_v, en_v, flag_q;
  logic               unused_mask;

  assign unused_mask = ^clr_mask_i[ST_SLEEP_ACK:ST_INIT_ACK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      ack_d_q <= 1'b1;
    end else begin
      err_q   <= err_stat_i;
      ack_d_q <= sleep_ack_i;
    end
  end

  assign set_v[FL_ERR]  = |(err_stat_i & ~err_q & err_en_i);
  assign set_v[FL_WAKE] = sof_i;
  assign set_v[FL_SLAK] = sleep_ack_i & ~ack_d_q;

  assign clr_v[FL_ERR]  = clr_wr_i & clr_mask_i[ST_ERR];
  assign clr_v[FL_WAKE] = clr_wr_i & clr_mask_i[ST_WAKE];
  assign clr_v[FL_SLAK] = (clr_wr_i & clr_mask_i[ST_SLAK]) | (~sleep_ack_i & ack_d_q);

  assign en_v[FL_ERR]  = irq_en_i[IE_ERR];
  assign en_v[FL_WAKE] = irq_en_i[IE_WAKE];
  assign en_v[FL_SLAK] = irq_en_i[IE_SLAK];

  for (genvar g = 0; g < FL_N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_v[g]) flag_q[g] <= 1'b1;
      else if (clr_v[g]) flag_q[g] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_v);

  AST_WAKE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q[FL_WAKE] && !(clr_wr_i && clr_mask_i[ST_WAKE]) |=> flag_q[FL_WAKE]) else $error("wake flag lost"); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q[FL_ERR] && !(clr_wr_i && clr_mask_i[ST_ERR]) |=> flag_q[FL_ERR]) else $error("error flag lost"); // R7
  AST_SLAK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_ack_i) |=> flag_q[FL_SLAK]) else $error("sleep-entered flag not set"); // R5
  AST_SLAK_HWCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_ack_i) |=> !flag_q[FL_SLAK]) else $error("sleep-entered flag not cleared"); // R9
  AST_WAKE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> flag_q[FL_WAKE]) else $error("wake flag not set"); // R6
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int unsigned SYNC_BITS = 11,
  parameter int unsigned NUM_ERR   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_wr_i,
  input  logic               ctrl_init_i,
  input  logic               ctrl_sleep_i,
  input  logic               auto_wake_i,
  input  logic [IE_W-1:0]    irq_en_i,
  input  logic [NUM_ERR-1:0] err_stat_i,
  input  logic [NUM_ERR-1:0] err_en_i,
  input  logic               rx_i,
  input  logic               bit_stb_i,
  input  logic               clr_wr_i,
  input  logic [ST_W-1:0]    clr_mask_i,
  output logic [ST_W-1:0]    status_o,
  output logic               sleep_req_o,
  output logic               irq_o
);
  logic            arm, sync_done, sof, init_ack, sleep_ack;
  logic [FL_N-1:0] flags;

  can_mode_sync #(.SYNC_BITS(SYNC_BITS)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm),
    .rx_i      (rx_i),
    .bit_stb_i (bit_stb_i),
    .done_o    (sync_done)
  );

  can_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_init_i  (ctrl_init_i),
    .ctrl_sleep_i (ctrl_sleep_i),
    .auto_wake_i  (auto_wake_i),
    .rx_i         (rx_i),
    .bit_stb_i    (bit_stb_i),
    .sync_done_i  (sync_done),
    .arm_o        (arm),
    .sof_o        (sof),
    .init_ack_o   (init_ack),
    .sleep_ack_o  (sleep_ack),
    .sleep_req_o  (sleep_req_o)
  );

  can_mode_irq #(.NUM_ERR(NUM_ERR)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_ack_i (sleep_ack),
    .sof_i       (sof),
    .err_stat_i  (err_stat_i),
    .err_en_i    (err_en_i),
    .clr_wr_i    (clr_wr_i),
    .clr_mask_i  (clr_mask_i),
    .irq_en_i    (irq_en_i),
    .flags_o     (flags),
    .irq_o       (irq_o)
  );

  assign status_o[ST_INIT_ACK]  = init_ack;
  assign status_o[ST_SLEEP_ACK] = sleep_ack;
  assign status_o[ST_ERR]       = flags[FL_ERR];
  assign status_o[ST_WAKE]      = flags[FL_WAKE];
  assign status_o[ST_SLAK]      = flags[FL_SLAK];

  // a drop to normal only happens on a recessive sample point
  AST_EXIT_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|$past(status_o[ST_SLEEP_ACK:ST_INIT_ACK])) && status_o[ST_SLEEP_ACK:ST_INIT_ACK] == 2'b00
      |-> $past(rx_i && bit_stb_i)) else $error("left mode without bus idle"); // R4
endmodule

// File: tb/can_mode_ctrl_tb.sv
`timescale 1ns/1ps
module can_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr, ini, slp, auto_w, rx, stb, clr_wr;
  logic [2:0] irq_en, err, err_en;
  logic [4:0] clr, status;
  logic       sleep_req, irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  can_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(wr), .ctrl_init_i(ini), .ctrl_sleep_i(slp),
    .auto_wake_i(auto_w), .irq_en_i(irq_en), .err_stat_i(err), .err_en_i(err_en),
    .rx_i(rx), .bit_stb_i(stb), .clr_wr_i(clr_wr), .clr_mask_i(clr),
    .status_o(status), .sleep_req_o(sleep_req), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, i, s, r, b, input logic [4:0] c, input logic [2:0] e);
    wr = w; ini = i; slp = s; rx = r; stb = b; clr = c; clr_wr = |c; err = e;
    @(posedge clk);
    @(negedge clk);
    wr = 0; clr = '0; clr_wr = 0; stb = 0; rx = 1;
  endtask

  // {wr, ini, slp, rx, stb, clr[4:0], err[2:0], exp_status[4:0], exp_irq}
  localparam int NV = 11;
  localparam logic [18:0] VEC [NV] = '{
    {5'b00010, 5'b00000, 3'b000, 5'b00010, 1'b0}, // R1 idle in sleep
    {5'b11110, 5'b00000, 3'b000, 5'b00010, 1'b0}, // R2 init write captured
    {5'b00010, 5'b00000, 3'b000, 5'b00001, 1'b0}, // R2 init ack, R3 over sleep
    {5'b10110, 5'b00000, 3'b000, 5'b00001, 1'b0}, // R5 sleep write captured
    {5'b00010, 5'b00000, 3'b000, 5'b00010, 1'b0}, // R5 sleep ack
    {5'b00010, 5'b00000, 3'b000, 5'b10010, 1'b1}, // R5 flag, R10
    {5'b00010, 5'b10000, 3'b000, 5'b00010, 1'b0}, // R8 clear
    {5'b00010, 5'b00000, 3'b001, 5'b00110, 1'b1}, // R7 error edge
    {5'b00010, 5'b00100, 3'b101, 5'b00010, 1'b0}, // R7 disabled type, R8
    {5'b00010, 5'b00011, 3'b000, 5'b00010, 1'b0}, // R8 ack bits not clearable
    {5'b00001, 5'b00000, 3'b000, 5'b01010, 1'b1}  // R6 start of frame
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr = 0; ini = 0; slp = 0; auto_w = 1; rx = 1; stb = 0;
    clr = '0; clr_wr = 0; err = '0; irq_en = 3'b111; err_en = 3'b011;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 status", status, 5'b00010);
    check("R1 irq", {4'b0, irq}, 5'b0);
    check("R1 sleep_req", {4'b0, sleep_req}, 5'b1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:9], VEC[i][8:6]);
      check($sformatf("table %0d status", i), status, VEC[i][5:1]);
      check($sformatf("table %0d irq R10", i), {4'b0, irq}, {4'b0, VEC[i][0]});
    end
    check("R6 auto clear", {4'b0, sleep_req}, 5'b0);

    // R4: exit from sleep with a dominant restart
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1, '0, '0);
    check("R4 ten bits hold", status, 5'b01010);
    step(0, 0, 0, 0, 1, '0, '0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1, '0, '0);
    check("R4 restart hold", status, 5'b01010);
    step(0, 0, 0, 1, 1, '0, '0);
    check("R4 eleventh bit exits", status, 5'b01000);
    step(0, 0, 0, 1, 0, 5'b01000, '0);
    check("R8 wake clear", status, 5'b00000);

    // R6 without auto wakeup, R9 hardware clear
    auto_w = 0;
    step(1, 0, 1, 1, 0, '0, '0);
    step(0, 0, 0, 1, 0, '0, '0);
    check("R5 sleep again", status, 5'b00010);
    step(0, 0, 0, 1, 0, '0, '0);
    check("R5 flag again", status, 5'b10010);
    step(0, 0, 0, 0, 1, '0, '0);
    check("R6 wake no auto", status, 5'b11010);
    check("R6 request kept", {4'b0, sleep_req}, 5'b1);
    step(0, 0, 0, 1, 0, 5'b01000, '0);
    step(1, 0, 0, 1, 0, '0, '0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1, '0, '0);
    check("R4 sleep hold", status, 5'b10010);
    step(0, 0, 0, 1, 1, '0, '0);
    check("R9 flag still set", status, 5'b10000);
    step(0, 0, 0, 1, 0, '0, '0);
    check("R9 hardware clear", status, 5'b00000);

    // R3 init wins from normal; R10 enable gating
    step(1, 1, 1, 1, 0, '0, '0);
    step(0, 0, 0, 1, 0, '0, '0);
    check("R3 init over sleep", status, 5'b00001);
    irq_en = 3'b011;
    step(0, 0, 0, 1, 0, '0, 3'b010);
    check("R7 error set", status, 5'b00101);
    check("R10 masked", {4'b0, irq}, 5'b0);
    irq_en = 3'b111;
    #1;
    check("R10 unmasked", {4'b0, irq}, 5'b1);
    step(0, 0, 0, 1, 0, 5'b00100, '0);

    // R4 exit from init, unstrobed dominant ignored
    step(1, 0, 0, 1, 0, '0, '0);
    check("R4 init pending", status, 5'b00001);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, '0, '0);
    step(0, 0, 0, 0, 0, '0, '0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, '0, '0);
    check("R4 ten with gap", status, 5'b00001);
    step(0, 0, 0, 1, 1, '0, '0);
    check("R4 init exit", status, 5'b00000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule